// File: doc/BRIEF.md
# Ethernet Link Mode Resolver

This block settles the speed and duplex of an Ethernet link. Local configuration has two parts, an auto-negotiation enable bit and a 2-bit mode field, loaded together by a write strobe. With negotiation off, the mode field names one fixed link mode. With negotiation on, the same field names the set of abilities offered to the partner. The block then either picks the best mode both ends offer, or falls back to parallel detection when the partner does not negotiate.

A small sequencer steps through idle, negotiate, parallel detect, link up and link failed. The partner's status comes in as plain level signals: negotiated, silent, the advertised ability vector and the detected speed. The result is driven on registered speed, duplex and link-valid outputs, with a separate failure flag. Every input and output is a plain control or status pin. There is no data stream, so no valid/ready handshake is used and no back-pressure applies.

Top module: `link_mode_resolver`

## Requirements
- R1: Reset clears link_up_o, link_fail_o, speed_o and duplex_o, and loads negotiation enabled with mode field 3.
- R2: Ability vectors use bit 0 = 10 half, bit 1 = 10 full, bit 2 = 100 half, bit 3 = 100 full. After a negotiation, the mode chosen is the highest-priority bit common to both ends, in the order 100 full, 100 half, 10 full, 10 half.
- R3: With negotiation disabled, mode field value m forces speed_o = m[1] (1 = 100 Mb/s) and duplex_o = m[0] (1 = full). link_up_o rises on the clock edge after the write edge.
- R4: With negotiation enabled, the mode field advertises the following sets: 0 gives both 10 Mb/s modes, 1 gives both 100 Mb/s modes, 2 gives both half-duplex modes, and 3 gives all four.
- R5: In the negotiate state, a partner-negotiated indication resolves on that same edge. With a write at edge w, the link is up after edge w+2.
- R6: A silent partner leads to parallel detect. The link comes up at partner_speed_i with half duplex, after edge w+3.
- R7: If the partner negotiated but no mode is common to both ends, link_fail_o rises and link_up_o stays low.
- R8: If parallel detect finds a speed whose half-duplex mode is not advertised locally, the link fails.
- R9: A configuration write restarts from idle and clears link_up_o and link_fail_o on the write edge, from any state.
- R10: With no partner indication, negotiate gives way to parallel detect after tmo_limit_i+1 cycles in that state. The link is up after edge w+tmo_limit_i+3.
- R11: speed_o and duplex_o change only on entry to link up. They hold while the link is up or failed, whatever the partner inputs do.
- R12: When partner-negotiated and partner-silent are both high, the negotiated result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Loads enable and mode field, restarts resolution |
| cfg_an_en_i | input | 1 | Negotiation enable to load |
| cfg_mode_i | input | 2 | Mode field to load |
| tmo_limit_i | input | TMO_W | Negotiate timeout, in cycles minus one |
| partner_an_done_i | input | 1 | Partner completed negotiation |
| partner_silent_i | input | 1 | Partner cannot negotiate |
| partner_abil_i | input | 4 | Partner ability vector, R2 bit order |
| partner_speed_i | input | 1 | Detected partner speed, 1 = 100 Mb/s |
| link_up_o | output | 1 | Link valid |
| link_fail_o | output | 1 | Resolution failed |
| speed_o | output | 1 | 1 = 100 Mb/s |
| duplex_o | output | 1 | 1 = full duplex |

## Verification
The forced path is tried with all four mode values. Each value must appear on its own speed and duplex bits, which separates a swapped or inverted mapping. Negotiation is tried with local sets against partner vectors that are full, single-bit and disjoint, so that the priority order, each advertised-set decode and the empty-intersection failure are told apart. Silent partners at both speeds, the timeout path at limits 0 and 3, and both indications raised together separate parallel detect from negotiation and pin the timeout count to the cycle.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_NEGO = 3'd1,
    ST_PDET = 3'd2,
    ST_UP   = 3'd3,
    ST_FAIL = 3'd4
  } lmr_state_e;

  localparam int NUM_MODES = 4;
  localparam int MODE_IDX_W = $clog2(NUM_MODES);

  typedef struct packed {
    logic speed;
    logic duplex;
  } link_mode_t;
endpackage

// File: rtl/lmr_adv_decode.sv
module lmr_adv_decode
  import lmr_pkg::*;
(
  input  logic [1:0]           mode_i,
  output logic [NUM_MODES-1:0] adv_o,
  output link_mode_t           forced_o
);
  // Forced mode: field bits map straight onto speed/duplex
  assign forced_o.speed  = mode_i[1];
  assign forced_o.duplex = mode_i[0];

  for (genvar i = 0; i < NUM_MODES; i++) begin : g_bit
    localparam logic BIT_SPD = 1'(i >> 1);
    localparam logic BIT_DUP = 1'(i & 1);
    always_comb begin
      unique case (mode_i)
        2'd0:    adv_o[i] = ~BIT_SPD;
        2'd1:    adv_o[i] = BIT_SPD;
        2'd2:    adv_o[i] = ~BIT_DUP;
        default: adv_o[i] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/lmr_best_pick.sv
module lmr_best_pick #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     cand_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // Highest set index wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/lmr_nego_timer.sv
module lmr_nego_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/link_mode_resolver.sv
module link_mode_resolver
  import lmr_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we_i,
  input  logic                 cfg_an_en_i,
  input  logic [1:0]           cfg_mode_i,
  input  logic [TMO_W-1:0]     tmo_limit_i,
  input  logic                 partner_an_done_i,
  input  logic                 partner_silent_i,
  input  logic [NUM_MODES-1:0] partner_abil_i,
  input  logic                 partner_speed_i,
  output logic                 link_up_o,
  output logic                 link_fail_o,
  output logic                 speed_o,
  output logic                 duplex_o
);
  lmr_state_e state_q, state_d;
  logic       an_en_q;
  logic [1:0] mode_q;
  logic       up_q;
  link_mode_t res_q, res_d;
  logic       load_res;

  logic [NUM_MODES-1:0]  adv_set;
  link_mode_t            forced_mode;
  logic [NUM_MODES-1:0]  common;
  logic                  common_found;
  logic [MODE_IDX_W-1:0] common_idx;
  logic                  tmo_expired;
  logic [MODE_IDX_W-1:0] pd_idx;

  lmr_adv_decode u_adv (
    .mode_i   (mode_q),
    .adv_o    (adv_set),
    .forced_o (forced_mode)
  );

  assign common = partner_abil_i & adv_set;

  lmr_best_pick #(.N(NUM_MODES)) u_pick (
    .cand_i  (common),
    .found_o (common_found),
    .idx_o   (common_idx)
  );

  lmr_nego_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (state_q == ST_NEGO),
    .limit_i   (tmo_limit_i),
    .expired_o (tmo_expired)
  );

  // Parallel detect always lands on the half-duplex mode of the sensed speed
  assign pd_idx = {partner_speed_i, 1'b0};

  always_comb begin
    state_d  = state_q;
    res_d    = res_q;
    load_res = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!an_en_q) begin
          state_d  = ST_UP;
          res_d    = forced_mode;
          load_res = 1'b1;
        end else begin
          state_d = ST_NEGO;
        end
      end
      ST_NEGO: begin
        if (partner_an_done_i) begin
          if (common_found) begin
            state_d  = ST_UP;
            res_d    = link_mode_t'(common_idx);
            load_res = 1'b1;
          end else begin
            state_d = ST_FAIL;
          end
        end else if (partner_silent_i || tmo_expired) begin
          state_d = ST_PDET;
        end
      end
      ST_PDET: begin
        if (adv_set[pd_idx]) begin
          state_d  = ST_UP;
          res_d    = link_mode_t'(pd_idx);
          load_res = 1'b1;
        end else begin
          state_d = ST_FAIL;
        end
      end
      ST_UP:   state_d = ST_UP;
      default: state_d = ST_FAIL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      an_en_q <= 1'b1;
      mode_q  <= 2'd3;
      up_q    <= 1'b0;
      res_q   <= '0;
    end else if (cfg_we_i) begin
      state_q <= ST_IDLE;
      an_en_q <= cfg_an_en_i;
      mode_q  <= cfg_mode_i;
      up_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_res) begin
        up_q  <= 1'b1;
        res_q <= res_d;
      end
    end
  end

  assign link_up_o   = up_q;
  assign link_fail_o = (state_q == ST_FAIL);
  assign speed_o     = res_q.speed;
  assign duplex_o    = res_q.duplex;
endmodule

// File: rtl/lmr_checker.sv
module lmr_checker
  import lmr_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_we_i,
  input logic                 cfg_an_en_i,
  input logic                 partner_an_done_i,
  input logic [NUM_MODES-1:0] partner_abil_i,
  input logic [NUM_MODES-1:0] adv_set,
  input lmr_state_e           state_q,
  input logic                 link_up_o,
  input logic                 link_fail_o,
  input logic                 speed_o,
  input logic                 duplex_o
);
  logic seen_clk;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_clk <= 1'b0;
    else        seen_clk <= 1'b1;
  end

  // R7
  up_fail_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_up_o && link_fail_o));

  // R9
  write_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i |=> (!link_up_o && !link_fail_o));

  // R3
  forced_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && !cfg_an_en_i) ##1 !cfg_we_i |=> link_up_o);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_clk && !$rose(link_up_o)) |-> $stable({speed_o, duplex_o}));

  // R6
  pdet_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PDET && !cfg_we_i) |=> (link_up_o ? !duplex_o : link_fail_o));

  // R7
  empty_common_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NEGO && !cfg_we_i && partner_an_done_i
     && ((partner_abil_i & adv_set) == '0)) |=> link_fail_o);
endmodule

bind link_mode_resolver lmr_checker u_lmr_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .cfg_we_i          (cfg_we_i),
  .cfg_an_en_i       (cfg_an_en_i),
  .partner_an_done_i (partner_an_done_i),
  .partner_abil_i    (partner_abil_i),
  .adv_set           (adv_set),
  .state_q           (state_q),
  .link_up_o         (link_up_o),
  .link_fail_o       (link_fail_o),
  .speed_o           (speed_o),
  .duplex_o          (duplex_o)
);

// File: tb/tb_link_mode_resolver.sv
module tb_link_mode_resolver;
  localparam int TMO_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we_i = 1'b0, cfg_an_en_i = 1'b1;
  logic [1:0] cfg_mode_i = 2'd3;
  logic [TMO_W-1:0] tmo_limit_i = 8'd4;
  logic partner_an_done_i = 1'b1, partner_silent_i = 1'b0, partner_speed_i = 1'b0;
  logic [3:0] partner_abil_i = 4'b1111;
  logic link_up_o, link_fail_o, speed_o, duplex_o;

  always #2 clk = ~clk;

  link_mode_resolver #(.TMO_W(TMO_W)) dut (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_tag = "R1";
  bit done = 0;

  // Behavioural reference
  int m_st; bit m_en, m_up, m_spd, m_dup; bit [1:0] m_mode; int m_cnt;
  function automatic bit [3:0] adv_of(bit [1:0] m);
    case (m)
      2'd0: return 4'b0011;
      2'd1: return 4'b1100;
      2'd2: return 4'b0101;
      default: return 4'b1111;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_en = 1; m_mode = 3; m_cnt = 0; m_up = 0; m_spd = 0; m_dup = 0;
    end else if (cfg_we_i) begin
      m_en = cfg_an_en_i; m_mode = cfg_mode_i; m_st = 0; m_up = 0;
    end else begin
      case (m_st)
        0: if (!m_en) begin m_up = 1; m_spd = m_mode[1]; m_dup = m_mode[0]; m_st = 3; end
           else begin m_st = 1; m_cnt = 0; end
        1: if (partner_an_done_i) begin
             bit [3:0] both; bit got;
             both = partner_abil_i & adv_of(m_mode); got = 0;
             for (int k = 3; k >= 0; k--)
               if (both[k] && !got) begin got = 1; m_spd = (k >= 2); m_dup = (k % 2 == 1); end
             if (got) begin m_up = 1; m_st = 3; end else m_st = 4;
           end else if (partner_silent_i || m_cnt == int'(tmo_limit_i)) m_st = 2;
           else m_cnt++;
        2: if (adv_of(m_mode)[partner_speed_i ? 2 : 0]) begin
             m_up = 1; m_spd = partner_speed_i; m_dup = 0; m_st = 3;
           end else m_st = 4;
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if ({link_up_o, link_fail_o, speed_o, duplex_o} !== {m_up, m_st == 4, m_spd, m_dup}) begin
        n_fail++;
        $display("FAIL %s model cycle %0d actual=%b expected=%b", cur_tag, cyc,
                 {link_up_o, link_fail_o, speed_o, duplex_o}, {m_up, m_st == 4, m_spd, m_dup});
      end
    end
  end

  task automatic chk(string tag, logic [3:0] exp, logic [3:0] mask);
    logic [3:0] act;
    act = {link_up_o, link_fail_o, speed_o, duplex_o};
    n_chk++;
    if ((act & mask) !== (exp & mask)) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b (mask %b)", tag, act, exp, mask);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit en, bit [1:0] m);
    @(negedge clk);
    cfg_we_i = 1; cfg_an_en_i = en; cfg_mode_i = m;
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  task automatic partner(bit dn, bit [3:0] ab, bit sil, bit spd);
    partner_an_done_i = dn; partner_abil_i = ab; partner_silent_i = sil; partner_speed_i = spd;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog (all) actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R1 during reset", 4'b0000, 4'b1111);
    rst_n = 1;
    step(2);
    chk("R1 default advertises all", 4'b1011, 4'b1111);

    cur_tag = "R3";
    for (int m = 0; m < 4; m++) begin
      wr(0, 2'(m));
      chk("R9 link drops on write", 4'b0000, 4'b1100);
      step(1);
      chk("R3 forced mode", {2'b10, 2'(m)}, 4'b1111);
    end

    cur_tag = "R4";
    partner(1, 4'b1111, 0, 0);
    wr(1, 0); step(1); chk("R5 not up after one edge", 4'b0000, 4'b1100);
    step(1); chk("R4 mode0 -> 10 full", 4'b1001, 4'b1111);
    wr(1, 1); step(2); chk("R4 mode1 -> 100 full", 4'b1011, 4'b1111);
    wr(1, 2); step(2); chk("R4 mode2 -> 100 half", 4'b1010, 4'b1111);

    cur_tag = "R2";
    partner(1, 4'b0011, 0, 0);
    wr(1, 3); step(2); chk("R2 best is 10 full", 4'b1001, 4'b1111);
    partner(1, 4'b0001, 0, 0);
    wr(1, 3); step(2); chk("R2 only 10 half", 4'b1000, 4'b1111);

    cur_tag = "R7";
    partner(1, 4'b0010, 0, 0);
    wr(1, 2); step(2); chk("R7 empty common fails", 4'b0100, 4'b1100);

    cur_tag = "R12";
    partner(1, 4'b1000, 1, 0);
    wr(1, 3); step(2); chk("R12 negotiated beats silent", 4'b1011, 4'b1111);

    cur_tag = "R6";
    partner(0, 4'b0000, 1, 1);
    wr(1, 3); step(2); chk("R6 not yet up", 4'b0000, 4'b1100);
    step(1); chk("R6 parallel detect 100 half", 4'b1010, 4'b1111);
    partner(0, 4'b0000, 1, 0);
    wr(1, 3); step(3); chk("R6 parallel detect 10 half", 4'b1000, 4'b1111);

    cur_tag = "R8";
    wr(1, 1); step(3); chk("R8 10 not advertised", 4'b0100, 4'b1100);
    partner(0, 4'b0000, 1, 1);
    wr(1, 0); step(3); chk("R8 100 not advertised", 4'b0100, 4'b1100);

    cur_tag = "R10";
    partner(0, 4'b0000, 0, 1); tmo_limit_i = 8'd3;
    wr(1, 3); step(5); chk("R10 still negotiating", 4'b0000, 4'b1100);
    step(1); chk("R10 timeout to parallel detect", 4'b1010, 4'b1111);

    cur_tag = "R11";
    partner(1, 4'b1111, 1, 0);
    step(5); chk("R11 held while up", 4'b1010, 4'b1111);
    partner(1, 4'b0010, 0, 0);
    wr(1, 2); step(2); chk("R11 held on failure", 4'b0110, 4'b1111);

    cur_tag = "R10";
    partner(0, 4'b0000, 0, 0); tmo_limit_i = 8'd0;
    wr(1, 3); step(2); chk("R10 zero limit not yet", 4'b0000, 4'b1100);
    step(1); chk("R10 zero limit up", 4'b1000, 4'b1111);

    cur_tag = "R9";
    tmo_limit_i = 8'd200;
    wr(1, 3); step(3); chk("R9 negotiating", 4'b0000, 4'b1100);
    wr(0, 1); step(1); chk("R9 write restarts from negotiate", 4'b1001, 4'b1111);

    step(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule